// File: doc/BRIEF.md
# Color Palette Lookup with Sequential RGB Loading

This block holds a 256-entry color table, each entry carrying an 8-bit red, green and blue value, and turns pixel words into 24-bit RGB. The host reaches it through one byte-wide write bus with a two-bit port select. The address port sets an index. The table data port then takes red, green and blue as three consecutive bytes, and the full entry is committed when the blue byte arrives. A third port, the configuration data port, writes the small register bank that the address port points at. Register 0x20 holds the depth-control byte and register 0x21 holds the memory bank select.

On the pixel side, bits [3:2] of the depth-control byte choose how a pixel word is read. In indexed 8-bit mode the low byte selects one whole entry. In 16-bit 5:5:5 mode and 32-bit 8:8:8 mode each channel field picks its own entry, and only that entry's matching channel is used. This gives a per-channel transfer curve for direct color. The two values in each depth pair differ only in bits [5:4], which record whether the larger memory configuration is present, so both values select the same pixel decode.

Top module: `clut_palette`

## Requirements
- R1: After reset, out_valid is 0, out_rgb is 0, depth_ctrl is 0x00 and bank_sel is 0x00. A depth of 0x00 selects indexed mode.
- R2: A write with host_sel=0 loads the entry index. Three following writes with host_sel=1 supply red, green and blue in that order. The entry at that index becomes {red,green,blue} when the blue write is accepted.
- R3: After each committed entry, the channel phase returns to red and the index increments by one, wrapping from 255 to 0. Further host_sel=1 writes therefore fill consecutive entries without a new address write.
- R4: Any host_sel=0 write resets the channel phase to red. Bytes from an unfinished red/green sequence are discarded, and the table entry they were aimed at keeps its previous value.
- R5: A host_sel=2 write stores the byte into depth_ctrl when the index is 0x20 and into bank_sel when the index is 0x21. At any other index it changes neither output.
- R6: Mode decode uses depth_ctrl[3:2]: 2'b01 selects 16-bit 5:5:5, 2'b10 selects 32-bit 8:8:8, and 2'b00 or 2'b11 select indexed 8-bit. Bits outside [3:2] do not affect the decode.
- R7: In indexed mode, out_rgb equals the entry at pix_data[7:0], and pix_data[31:8] are ignored.
- R8: In 16-bit mode, red is pix_data[14:10], green is pix_data[9:5] and blue is pix_data[4:0]. Each 5-bit field f is widened to the 8-bit index {f, f[4:2]}. out_rgb takes red from the red field's entry, green from the green field's entry and blue from the blue field's entry.
- R9: In 32-bit mode, red is pix_data[23:16], green is pix_data[15:8] and blue is pix_data[7:0]. Each field indexes its own channel as in R8, and pix_data[31:24] is ignored.
- R10: out_valid is pix_valid delayed by exactly one clock. out_rgb updates only on cycles where pix_valid is 1 and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one write per cycle |
| host_sel | input | 2 | 0 address port, 1 table data port, 2 configuration data port, 3 unused |
| host_wdata | input | 8 | Host write byte |
| pix_valid | input | 1 | Pixel word valid |
| pix_data | input | 32 | Pixel word |
| out_valid | output | 1 | RGB result valid |
| out_rgb | output | 24 | Result, red [23:16], green [15:8], blue [7:0] |
| depth_ctrl | output | 8 | Depth-control register (index 0x20) |
| bank_sel | output | 8 | Memory bank select register (index 0x21) |

## Verification
The hardest states to reach from the ports are the index wrap from 255 to 0 and a load sequence cut short partway. To reach the wrap, the bench streams 768 data bytes after a single address write, so the whole table fills by auto-increment. Three more bytes are then sent, and those must land in entry 0. For the cut-short case, the bench abandons a red/green pair with a fresh address write. It then confirms through indexed lookups that the target entry kept its old value and that the next byte was taken as red. Direct-mode checks choose field values whose widened indices land on entries with distinct contents in every channel, so a swapped field or a wrong widening shows up in out_rgb.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam int CH_W    = 8;
  localparam int IDX_W   = 8;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int RGB_W   = 3 * CH_W;
  localparam int FLD5_W  = 5;

  localparam logic [IDX_W-1:0] REG_DEPTH = 8'h20;
  localparam logic [IDX_W-1:0] REG_BANK  = 8'h21;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_LUT  = 2'd1,
    SEL_CFG  = 2'd2,
    SEL_NONE = 2'd3
  } host_sel_e;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    MODE_IDX,
    MODE_555,
    MODE_888
  } pix_mode_e;

  function automatic logic [IDX_W-1:0] widen5(input logic [FLD5_W-1:0] f);
    return {f, f[FLD5_W-1 -: (IDX_W - FLD5_W)]};
  endfunction

  function automatic pix_mode_e decode_mode(input logic [CH_W-1:0] depth);
    case (depth[3:2])
      2'b01:   return MODE_555;
      2'b10:   return MODE_888;
      default: return MODE_IDX;
    endcase
  endfunction
endpackage

// File: rtl/clut_host_port.sv
module clut_host_port
  import clut_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [1:0]       host_sel,
  input  logic [CH_W-1:0]  host_wdata,
  output logic             lut_we,
  output logic [IDX_W-1:0] lut_idx,
  output logic [RGB_W-1:0] lut_wdata,
  output logic [1:0]       phase,
  output logic [CH_W-1:0]  depth_ctrl,
  output logic [CH_W-1:0]  bank_sel
);
  logic [IDX_W-1:0] idx_q, idx_d;
  phase_e           ph_q, ph_d;
  logic [CH_W-1:0]  red_q, red_d, grn_q, grn_d;
  logic [CH_W-1:0]  dep_q, dep_d, bnk_q, bnk_d;
  logic             we_c;

  always_comb begin
    idx_d = idx_q;
    ph_d  = ph_q;
    red_d = red_q;
    grn_d = grn_q;
    dep_d = dep_q;
    bnk_d = bnk_q;
    we_c  = 1'b0;
    if (host_wr) begin
      case (host_sel_e'(host_sel))
        SEL_ADDR: begin
          idx_d = host_wdata[IDX_W-1:0];
          ph_d  = PH_RED;
        end
        SEL_LUT: begin
          case (ph_q)
            PH_RED: begin red_d = host_wdata; ph_d = PH_GRN; end
            PH_GRN: begin grn_d = host_wdata; ph_d = PH_BLU; end
            default: begin
              we_c  = 1'b1;
              ph_d  = PH_RED;
              idx_d = idx_q + 1'b1;
            end
          endcase
        end
        SEL_CFG: begin
          if (idx_q == REG_DEPTH)     dep_d = host_wdata;
          else if (idx_q == REG_BANK) bnk_d = host_wdata;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      ph_q  <= PH_RED;
      red_q <= '0;
      grn_q <= '0;
      dep_q <= '0;
      bnk_q <= '0;
    end else begin
      idx_q <= idx_d;
      ph_q  <= ph_d;
      red_q <= red_d;
      grn_q <= grn_d;
      dep_q <= dep_d;
      bnk_q <= bnk_d;
    end
  end

  assign lut_we     = we_c;
  assign lut_idx    = idx_q;
  assign lut_wdata  = {red_q, grn_q, host_wdata};
  assign phase      = ph_q;
  assign depth_ctrl = dep_q;
  assign bank_sel   = bnk_q;
endmodule

// File: rtl/clut_store.sv
module clut_store
  import clut_pkg::*;
#(
  parameter int RD_PORTS = 3
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [RGB_W-1:0] wdata,
  input  logic [IDX_W-1:0] ridx  [RD_PORTS],
  output logic [RGB_W-1:0] rdata [RD_PORTS]
);
  logic [RGB_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    assign rdata[p] = mem[ridx[p]];
  end
endmodule

// File: rtl/clut_pixel_path.sv
module clut_pixel_path
  import clut_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CH_W-1:0]  depth_ctrl,
  input  logic             pix_valid,
  input  logic [31:0]      pix_data,
  output logic [IDX_W-1:0] ridx  [3],
  input  logic [RGB_W-1:0] rdata [3],
  output logic             out_valid,
  output logic [RGB_W-1:0] out_rgb
);
  localparam int R_HI = 3 * CH_W - 1;
  localparam int G_HI = 2 * CH_W - 1;
  localparam int B_HI = CH_W - 1;

  pix_mode_e        mode;
  logic [RGB_W-1:0] rgb_d;
  logic             vld_q;
  logic [RGB_W-1:0] rgb_q;

  assign mode = decode_mode(depth_ctrl);

  always_comb begin
    case (mode)
      MODE_555: begin
        ridx[0] = widen5(pix_data[14:10]);
        ridx[1] = widen5(pix_data[9:5]);
        ridx[2] = widen5(pix_data[4:0]);
      end
      MODE_888: begin
        ridx[0] = pix_data[23:16];
        ridx[1] = pix_data[15:8];
        ridx[2] = pix_data[7:0];
      end
      default: begin
        ridx[0] = pix_data[IDX_W-1:0];
        ridx[1] = pix_data[IDX_W-1:0];
        ridx[2] = pix_data[IDX_W-1:0];
      end
    endcase
    rgb_d = {rdata[0][R_HI -: CH_W], rdata[1][G_HI -: CH_W], rdata[2][B_HI -: CH_W]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      rgb_q <= '0;
    end else begin
      vld_q <= pix_valid;
      if (pix_valid) rgb_q <= rgb_d;
    end
  end

  assign out_valid = vld_q;
  assign out_rgb   = rgb_q;
endmodule

// File: rtl/clut_palette.sv
module clut_palette
  import clut_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [1:0]  host_sel,
  input  logic [7:0]  host_wdata,
  input  logic        pix_valid,
  input  logic [31:0] pix_data,
  output logic        out_valid,
  output logic [23:0] out_rgb,
  output logic [7:0]  depth_ctrl,
  output logic [7:0]  bank_sel
);
  logic             lut_we;
  logic [IDX_W-1:0] lut_idx;
  logic [RGB_W-1:0] lut_wdata;
  logic [1:0]       phase;
  logic [IDX_W-1:0] ridx  [3];
  logic [RGB_W-1:0] rdata [3];

  clut_host_port u_host (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .lut_we     (lut_we),
    .lut_idx    (lut_idx),
    .lut_wdata  (lut_wdata),
    .phase      (phase),
    .depth_ctrl (depth_ctrl),
    .bank_sel   (bank_sel)
  );

  clut_store #(.RD_PORTS(3)) u_store (
    .clk   (clk),
    .we    (lut_we),
    .widx  (lut_idx),
    .wdata (lut_wdata),
    .ridx  (ridx),
    .rdata (rdata)
  );

  clut_pixel_path u_pix (
    .clk        (clk),
    .rst_n      (rst_n),
    .depth_ctrl (depth_ctrl),
    .pix_valid  (pix_valid),
    .pix_data   (pix_data),
    .ridx       (ridx),
    .rdata      (rdata),
    .out_valid  (out_valid),
    .out_rgb    (out_rgb)
  );
endmodule

// File: rtl/clut_palette_chk.sv
module clut_palette_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr,
  input logic [1:0] host_sel,
  input logic       pix_valid,
  input logic       out_valid,
  input logic [23:0] out_rgb,
  input logic [7:0] depth_ctrl,
  input logic [7:0] bank_sel,
  input logic       lut_we,
  input logic [7:0] lut_idx,
  input logic [1:0] phase
);
  assert_addr_resets_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel == 2'd0) |=> (phase == 2'd0));

  assert_commit_advances_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lut_we |=> (phase == 2'd0 && lut_idx == $past(lut_idx) + 8'd1));

  assert_phase_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3);

  assert_cfg_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && host_sel == 2'd2) |=> ($stable(depth_ctrl) && $stable(bank_sel)));

  assert_valid_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);

  assert_rgb_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> (!out_valid && $stable(out_rgb)));
endmodule

bind clut_palette clut_palette_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_wr    (host_wr),
  .host_sel   (host_sel),
  .pix_valid  (pix_valid),
  .out_valid  (out_valid),
  .out_rgb    (out_rgb),
  .depth_ctrl (depth_ctrl),
  .bank_sel   (bank_sel),
  .lut_we     (lut_we),
  .lut_idx    (lut_idx),
  .phase      (phase)
);

// File: tb/clut_palette_tb.sv
`timescale 1ns/1ps
module clut_palette_tb;
  logic        clk;
  logic        rst_n;
  logic        host_wr;
  logic [1:0]  host_sel;
  logic [7:0]  host_wdata;
  logic        pix_valid;
  logic [31:0] pix_data;
  logic        out_valid;
  logic [23:0] out_rgb;
  logic [7:0]  depth_ctrl;
  logic [7:0]  bank_sel;

  int tests_run  = 0;
  int tests_fail = 0;
  bit finished   = 0;

  logic [23:0] exp_tab [256];
  logic [7:0]  m_idx;
  int          m_phase;
  logic [7:0]  m_r, m_g;

  clut_palette u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .pix_valid(pix_valid), .pix_data(pix_data),
    .out_valid(out_valid), .out_rgb(out_rgb), .depth_ctrl(depth_ctrl),
    .bank_sel(bank_sel)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests_run++;
    if (act !== exp) begin
      tests_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic wr_addr(input logic [7:0] a);
    host_write(2'd0, a);
    m_idx = a; m_phase = 0;
  endtask

  task automatic wr_lut(input logic [7:0] d);
    host_write(2'd1, d);
    case (m_phase)
      0: begin m_r = d; m_phase = 1; end
      1: begin m_g = d; m_phase = 2; end
      default: begin
        exp_tab[m_idx] = {m_r, m_g, d};
        m_idx = m_idx + 8'd1; m_phase = 0;
      end
    endcase
  endtask

  task automatic set_cfg(input logic [7:0] a, input logic [7:0] d);
    wr_addr(a);
    host_write(2'd2, d);
  endtask

  task automatic lookup(input string req, input logic [31:0] pix, input logic [23:0] exp);
    @(negedge clk);
    pix_valid = 1'b1; pix_data = pix;
    @(negedge clk);
    pix_valid = 1'b0;
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check(req, {8'd0, out_rgb}, {8'd0, exp});
  endtask

  function automatic logic [7:0] w5(input logic [4:0] f);
    return {f, f[4:2]};
  endfunction

  task automatic t_reset();
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 out_rgb", {8'd0, out_rgb}, 32'd0);
    check("R1 depth", {24'd0, depth_ctrl}, 32'd0);
    check("R1 bank", {24'd0, bank_sel}, 32'd0);
  endtask

  task automatic t_fill();
    wr_addr(8'h00);
    for (int i = 0; i < 256; i++) begin
      wr_lut(8'(i) ^ 8'h5A);
      wr_lut(8'(i * 3));
      wr_lut(~8'(i));
    end
    lookup("R2 entry 0", 32'h0, exp_tab[0]);
    lookup("R3 entry 1", 32'h1, exp_tab[1]);
    lookup("R3 entry 127", 32'h7F, exp_tab[127]);
    lookup("R3 entry 255", 32'hFF, exp_tab[255]);
  endtask

  task automatic t_wrap();
    wr_lut(8'hAA); wr_lut(8'hBB); wr_lut(8'hCC);
    lookup("R3 wrap to 0", 32'h0, 24'hAABBCC);
    lookup("R3 entry 1 untouched", 32'h1, exp_tab[1]);
  endtask

  task automatic t_abort();
    logic [23:0] old10;
    old10 = exp_tab[10];
    wr_addr(8'd10); wr_lut(8'h11); wr_lut(8'h22);
    wr_addr(8'd40);
    lookup("R4 partial discarded", 32'd10, old10);
    wr_addr(8'd11); wr_lut(8'h99);
    wr_addr(8'd11); wr_lut(8'h31); wr_lut(8'h32); wr_lut(8'h33);
    lookup("R4 phase back to red", 32'd11, 24'h313233);
  endtask

  task automatic t_cfg();
    set_cfg(8'h21, 8'h01);
    check("R5 bank write", {24'd0, bank_sel}, 32'h01);
    set_cfg(8'h33, 8'h77);
    check("R5 other index depth", {24'd0, depth_ctrl}, 32'h00);
    check("R5 other index bank", {24'd0, bank_sel}, 32'h01);
    set_cfg(8'h20, 8'h10);
    check("R5 depth write", {24'd0, depth_ctrl}, 32'h10);
  endtask

  task automatic t_indexed();
    lookup("R7 upper bits ignored", 32'hFFFF_FF05, exp_tab[5]);
    lookup("R7 index 200", 32'h1234_00C8, exp_tab[200]);
  endtask

  task automatic t_555();
    logic [4:0] r5, g5, b5;
    set_cfg(8'h20, 8'h14);
    r5 = 5'd3; g5 = 5'd17; b5 = 5'd31;
    lookup("R8 555 a", {17'd0, r5, g5, b5},
      {exp_tab[w5(r5)][23:16], exp_tab[w5(g5)][15:8], exp_tab[w5(b5)][7:0]});
    r5 = 5'd28; g5 = 5'd1; b5 = 5'd9;
    lookup("R8 555 b", {17'h1FFFF, r5, g5, b5},
      {exp_tab[w5(r5)][23:16], exp_tab[w5(g5)][15:8], exp_tab[w5(b5)][7:0]});
    set_cfg(8'h20, 8'h24);
    r5 = 5'd12; g5 = 5'd22; b5 = 5'd6;
    lookup("R6 0x24 is 555", {17'd0, r5, g5, b5},
      {exp_tab[w5(r5)][23:16], exp_tab[w5(g5)][15:8], exp_tab[w5(b5)][7:0]});
  endtask

  task automatic t_888();
    set_cfg(8'h20, 8'h28);
    lookup("R9 888 a", 32'hEE_30_81_F2,
      {exp_tab[8'h30][23:16], exp_tab[8'h81][15:8], exp_tab[8'hF2][7:0]});
    set_cfg(8'h20, 8'h18);
    lookup("R9 888 b", 32'h00_07_64_A9,
      {exp_tab[8'h07][23:16], exp_tab[8'h64][15:8], exp_tab[8'hA9][7:0]});
  endtask

  task automatic t_mode11();
    set_cfg(8'h20, 8'h1C);
    lookup("R6 code 11 indexed", 32'h00_30_81_2D, exp_tab[8'h2D]);
  endtask

  task automatic t_hold();
    logic [23:0] held;
    lookup("R10 lookup", 32'h0000_0042, exp_tab[8'h42]);
    held = exp_tab[8'h42];
    @(negedge clk);
    pix_data = 32'h0000_0001;
    @(negedge clk);
    check("R10 valid drops", {31'd0, out_valid}, 32'd0);
    check("R10 rgb held", {8'd0, out_rgb}, {8'd0, held});
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      tests_run++;
      tests_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; host_wr = 1'b0; host_sel = 2'd0; host_wdata = 8'd0;
    pix_valid = 1'b0; pix_data = 32'd0;
    m_idx = 8'd0; m_phase = 0; m_r = 8'd0; m_g = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_wrap();
    t_abort();
    t_cfg();
    t_indexed();
    t_555();
    t_888();
    t_mode11();
    t_hold();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
    $finish;
  end
endmodule